// File: doc/BRIEF.md
# Channel Trigger Combiner with Event OR and Hold Request

This block is the digital trigger path for a bank of photodetector readout channels: sixteen detector channels and one summing channel, seventeen in all. Each channel receives two asynchronous comparator levels. One is a slow charge-threshold decision and the other a fast current decision that fires earlier and with less walk. Both are resynchronised to the system clock and merged per channel. Each channel then produces a timing pulse. In fixed-width mode a rising trigger edge starts a pulse of programmable length. In time-over-threshold mode the pulse simply tracks the merged comparator level.

The detector channel pulses are ORed into one event output. A hold request for the pulse-height capture and digitization sequencer is taken either from the OR of all seventeen channel pulses or from an external hold input. All settings come from one flat configuration word, which the block expects to change only while the channels are idle.

Top module: `evtrig_core`

## Requirements
- R1: A rising comparator level that is driven between clock edges appears on an enabled channel's trig_o bit on the third rising clock edge after the change.
- R2: A channel whose enable bit cfg_i[c] is 0 drives trig_o[c] low whatever its comparator inputs do, and neither event_o nor hold_o rises because of it.
- R3: With the mode bit cfg_i[17+c] at 0 (fixed width), a trigger edge produces a pulse on trig_o[c] lasting W+1 clock cycles, where W is the unsigned value of cfg_i[41:34].
- R4: In fixed-width mode, a new rising trigger edge that arrives while the pulse is active neither extends the pulse nor starts a second one.
- R5: With the mode bit cfg_i[17+c] at 1 (time over threshold), trig_o[c] follows the synchronised merged level of the channel, with the same three-edge latency, so an input high for H cycles gives an output high for H cycles.
- R6: Either comparator (qcmp_i[c] or icmp_i[c]) alone triggers channel c. When they overlap, the channel sees one continuous level and so one edge.
- R7: event_o is high exactly when one of trig_o[15:0] is high. The summing channel, trig_o[16], has no effect on event_o.
- R8: With cfg_i[42] at 0, hold_o is high exactly when any of the seventeen trig_o bits is high, the summing channel included.
- R9: With cfg_i[42] at 1, hold_o follows hold_ext_i with a three-edge latency and ignores all channel triggers.
- R10: While rst_n is low, and until the internal reset release has passed, trig_o, event_o and hold_o are low, even with comparator inputs held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| qcmp_i | input | 17 | Charge comparator levels, one per channel (bit 16 is the summing channel) |
| icmp_i | input | 17 | Current comparator levels, one per channel |
| hold_ext_i | input | 1 | External hold request level |
| cfg_i | input | 43 | Configuration: [16:0] enables, [33:17] modes, [41:34] width W, [42] external hold select |
| trig_o | output | 17 | Per-channel timing pulses |
| event_o | output | 1 | OR of the sixteen detector channel pulses |
| hold_o | output | 1 | Hold request to the readout sequencer |

## Verification
Every result leaves the block three clock edges after the input that caused it. Two of those edges are synchroniser stages. The third is the pulse register for channel outputs and an alignment stage for the external hold. The falling side has the same latency in time-over-threshold mode. A fixed pulse stays high for W+1 cycles from that third edge. The bench drives inputs at the falling edge and numbers the rising edges that follow. At each falling edge it compares the outputs with a window it computes from the stimulus length and from W. This covers the rising edge, the falling edge and the quiet cycles around the pulse.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;

  // Per-channel pulse shaping choice
  typedef enum logic {
    PM_FIXED = 1'b0,
    PM_TOT   = 1'b1
  } pmode_e;

  // Config word layout helpers (LSB positions of each field)
  function automatic int en_lsb(input int nch);
    return 0 * nch;
  endfunction

  function automatic int mode_lsb(input int nch);
    return nch;
  endfunction

  function automatic int width_lsb(input int nch);
    return 2 * nch;
  endfunction

endpackage

// File: rtl/evtrig_sync.sv
module evtrig_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) begin
        stg_q[k] <= stg_q[k-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/evtrig_chan.sv
module evtrig_chan
  import evtrig_pkg::*;
#(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_lvl_i,
  input  logic             i_lvl_i,
  input  logic             en_i,
  input  pmode_e           mode_i,
  input  logic [WID_W-1:0] width_i,
  output logic             trig_o
);

  logic             lvl;
  logic             rise;
  logic             prev_q;
  logic             act_q, act_d;
  logic [WID_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             tot_q, tot_d;

  // Next-state logic
  always_comb begin
    lvl    = q_lvl_i | i_lvl_i;
    rise   = lvl & ~prev_q;
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    tot_d  = en_i & lvl & (mode_i == PM_TOT);
    if (!en_i || (mode_i == PM_TOT)) begin
      act_d  = 1'b0;
      cnt_d  = '0;
      cnt_en = act_q;
    end else if (act_q) begin
      // edges during an active pulse are ignored
      if (cnt_q == '0) begin
        act_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - WID_W'(1);
        cnt_en = 1'b1;
      end
    end else if (rise) begin
      act_d  = 1'b1;
      cnt_d  = width_i;
      cnt_en = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      tot_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      act_q  <= act_d;
      tot_q  <= tot_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign trig_o = (mode_i == PM_TOT) ? tot_q : act_q;

endmodule

// File: rtl/evtrig_gather.sv
module evtrig_gather #(
  parameter int N_DET = 16,
  localparam int NCH  = N_DET + 1
) (
  input  logic [NCH-1:0] trig_i,
  input  logic           ext_sel_i,
  input  logic           ext_lvl_i,
  output logic           event_o,
  output logic           hold_o
);

  logic any_det;
  logic any_all;

  always_comb begin
    any_det = |trig_i[N_DET-1:0];
    any_all = any_det | trig_i[NCH-1];
    event_o = any_det;
    hold_o  = ext_sel_i ? ext_lvl_i : any_all;
  end

endmodule

// File: rtl/evtrig_core.sv
module evtrig_core
  import evtrig_pkg::*;
#(
  parameter int N_DET  = 16,
  parameter int WID_W  = 8,
  localparam int NCH   = N_DET + 1,
  localparam int CFG_W = 2 * NCH + WID_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   qcmp_i,
  input  logic [NCH-1:0]   icmp_i,
  input  logic             hold_ext_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [NCH-1:0]   trig_o,
  output logic             event_o,
  output logic             hold_o
);

  localparam int EN_LSB  = en_lsb(NCH);
  localparam int MD_LSB  = mode_lsb(NCH);
  localparam int WD_LSB  = width_lsb(NCH);
  localparam int HSEL_B  = WD_LSB + WID_W;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  // Configuration fields
  logic [NCH-1:0]   cfg_en;
  logic [NCH-1:0]   cfg_mode;
  logic [WID_W-1:0] cfg_width;
  logic             cfg_hsel;

  assign cfg_en    = cfg_i[EN_LSB +: NCH];
  assign cfg_mode  = cfg_i[MD_LSB +: NCH];
  assign cfg_width = cfg_i[WD_LSB +: WID_W];
  assign cfg_hsel  = cfg_i[HSEL_B];

  // Synchronisers
  logic [NCH-1:0] q_s;
  logic [NCH-1:0] i_s;
  logic           ext_s;

  evtrig_sync #(.W(NCH), .STAGES(2)) u_sync_q (
    .clk(clk), .rst_n(rst_int_n), .d_i(qcmp_i), .q_o(q_s)
  );

  evtrig_sync #(.W(NCH), .STAGES(2)) u_sync_i (
    .clk(clk), .rst_n(rst_int_n), .d_i(icmp_i), .q_o(i_s)
  );

  // third stage aligns the external path with the channel pulse register
  evtrig_sync #(.W(1), .STAGES(3)) u_sync_ext (
    .clk(clk), .rst_n(rst_int_n), .d_i(hold_ext_i), .q_o(ext_s)
  );

  // Channels (index NCH-1 is the summing channel)
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    evtrig_chan #(.WID_W(WID_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .q_lvl_i (q_s[g]),
      .i_lvl_i (i_s[g]),
      .en_i    (cfg_en[g]),
      .mode_i  (pmode_e'(cfg_mode[g])),
      .width_i (cfg_width),
      .trig_o  (trig_o[g])
    );
  end

  evtrig_gather #(.N_DET(N_DET)) u_gather (
    .trig_i    (trig_o),
    .ext_sel_i (cfg_hsel),
    .ext_lvl_i (ext_s),
    .event_o   (event_o),
    .hold_o    (hold_o)
  );

endmodule

// File: rtl/evtrig_chk.sv
module evtrig_chk #(
  parameter int N_DET  = 16,
  parameter int WID_W  = 8,
  localparam int NCH   = N_DET + 1,
  localparam int CFG_W = 2 * NCH + WID_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_ext_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic [NCH-1:0]   trig_o,
  input logic             event_o,
  input logic             hold_o
);

  logic [NCH-1:0]   en_f;
  logic [NCH-1:0]   md_f;
  logic [WID_W-1:0] wd_f;
  logic             hs_f;

  assign en_f = cfg_i[0 +: NCH];
  assign md_f = cfg_i[NCH +: NCH];
  assign wd_f = cfg_i[2*NCH +: WID_W];
  assign hs_f = cfg_i[2*NCH + WID_W];

  for (genvar g = 0; g < NCH; g++) begin : g_c
    // number of consecutive high cycles seen before the current one
    logic [WID_W:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_cnt <= '0;
      end else if (!trig_o[g]) begin
        hi_cnt <= '0;
      end else if (hi_cnt != '1) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
    end

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_f[g]) |-> !trig_o[g]);

    p_width_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o[g] && !md_f[g] |-> hi_cnt <= {1'b0, wd_f});

    p_width_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o[g] && !md_f[g] && en_f[g] && (hi_cnt < {1'b0, wd_f}) |=> trig_o[g]);
  end

  p_sum_no_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o[N_DET-1:0] == '0) |-> !event_o);

  p_hold_internal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_f && (event_o || trig_o[NCH-1]) |-> hold_o);

  p_hold_external_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_f && !$past(hold_ext_i, 3) |-> !hold_o);

endmodule

bind evtrig_core evtrig_chk #(.N_DET(N_DET), .WID_W(WID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold_ext_i (hold_ext_i),
  .cfg_i      (cfg_i),
  .trig_o     (trig_o),
  .event_o    (event_o),
  .hold_o     (hold_o)
);

// File: tb/sim_evtrig_core.sv
module sim_evtrig_core;

  localparam int N_DET = 16;
  localparam int WID_W = 8;
  localparam int NCH   = N_DET + 1;
  localparam int CFG_W = 2 * NCH + WID_W + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   qcmp = '0;
  logic [NCH-1:0]   icmp = '0;
  logic             hold_ext = 1'b0;
  logic [NCH-1:0]   en_v = '0;
  logic [NCH-1:0]   tot_v = '0;
  logic [WID_W-1:0] width_v = '0;
  logic             hsel = 1'b0;
  logic [CFG_W-1:0] cfg;
  logic [NCH-1:0]   trig;
  logic             evt;
  logic             hold;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  assign cfg = {hsel, width_v, tot_v, en_v};

  evtrig_core #(.N_DET(N_DET), .WID_W(WID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .qcmp_i(qcmp), .icmp_i(icmp),
    .hold_ext_i(hold_ext), .cfg_i(cfg),
    .trig_o(trig), .event_o(evt), .hold_o(hold)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One stimulus on channel c; R1 latency is part of every window below
  task automatic shot(input int c, input int src, input bit tot, input bit en,
                      input int w, input int h);
    logic [NCH-1:0] ev;
    bit hi;
    en_v = '1;
    en_v[c] = en;
    tot_v = '0;
    tot_v[c] = tot;
    width_v = WID_W'(w);
    hsel = 1'b0;
    @(negedge clk);
    if (src == 0) qcmp[c] = 1'b1;
    else          icmp[c] = 1'b1;
    for (int t = 1; t <= (tot ? h + 2 : w + 3) + 4; t++) begin
      @(posedge clk);
      @(negedge clk);
      if (t == h) begin
        qcmp = '0;
        icmp = '0;
      end
      hi = en && (t >= 3) && (tot ? (t <= h + 2) : (t <= w + 3));
      ev = '0;
      if (hi) ev[c] = 1'b1;
      chk($sformatf("%s%s ch%0d src%0d t%0d trig", en ? "" : "R2 ",
                    tot ? "R5" : "R3", c, src, t), 32'(trig), 32'(ev));
      chk($sformatf("R7 ch%0d t%0d event", c, t), 32'(evt), 32'(hi && (c < N_DET)));
      chk($sformatf("R8 ch%0d t%0d hold", c, t), 32'(hold), 32'(hi));
    end
  endtask

  // R9: external hold source, with or without channel activity
  task automatic ext_case(input int h, input bit use_chan);
    logic [NCH-1:0] ev;
    bit hx, hc;
    en_v = '1;
    tot_v = '0;
    width_v = WID_W'(2);
    hsel = 1'b1;
    @(negedge clk);
    if (use_chan) qcmp[5] = 1'b1;
    else          hold_ext = 1'b1;
    for (int t = 1; t <= h + 6; t++) begin
      @(posedge clk);
      @(negedge clk);
      if (t == h) begin
        qcmp = '0;
        hold_ext = 1'b0;
      end
      hx = !use_chan && (t >= 3) && (t <= h + 2);
      hc = use_chan && (t >= 3) && (t <= 5);
      ev = '0;
      if (hc) ev[5] = 1'b1;
      chk($sformatf("R9 t%0d hold chan%0d", t, use_chan), 32'(hold), 32'(hx));
      chk($sformatf("R9 t%0d trig", t), 32'(trig), 32'(ev));
      chk($sformatf("R7 t%0d event", t), 32'(evt), 32'(hc));
    end
    hsel = 1'b0;
  endtask

  initial begin
    // R10: reset holds outputs low even with active inputs
    qcmp = '1;
    en_v = '1;
    repeat (3) @(negedge clk);
    chk("R10 trig in reset", 32'(trig), 32'h0);
    chk("R10 event in reset", 32'(evt), 32'h0);
    chk("R10 hold in reset", 32'(hold), 32'h0);
    qcmp = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 trig after release", 32'(trig), 32'h0);
    repeat (6) @(negedge clk);

    // Sweep: every channel, both sources (R6), both modes
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int m = 0; m < 2; m++) begin
          shot(c, s, m[0], 1'b1, (c + s) % 5, 1 + (c + 2 * s + m) % 4);
        end
      end
    end

    // R2: disabled channels stay silent
    for (int c = 0; c < NCH; c += 4) begin
      shot(c, c % 2, 1'b0, 1'b0, 3, 2);
      shot(c, 1 - c % 2, 1'b1, 1'b0, 3, 3);
    end

    // R3 boundary: largest width
    shot(9, 0, 1'b0, 1'b1, 255, 1);

    // R4: retrigger during an active pulse, channel 3, W = 6
    begin
      en_v = '1; tot_v = '0; width_v = 8'd6; hsel = 1'b0;
      @(negedge clk);
      qcmp[3] = 1'b1;
      for (int t = 1; t <= 14; t++) begin
        @(posedge clk);
        @(negedge clk);
        if (t == 1) qcmp[3] = 1'b0;
        if (t == 2) qcmp[3] = 1'b1;
        if (t == 3) qcmp[3] = 1'b0;
        chk($sformatf("R4 retrigger t%0d", t), 32'(trig),
            (t >= 3 && t <= 9) ? 32'h8 : 32'h0);
      end
    end

    // R4/R6: overlapping current then charge on the summing channel, W = 1
    begin
      en_v = '1; tot_v = '0; width_v = 8'd1;
      @(negedge clk);
      icmp[16] = 1'b1;
      for (int t = 1; t <= 10; t++) begin
        @(posedge clk);
        @(negedge clk);
        if (t == 1) qcmp[16] = 1'b1;
        if (t == 2) icmp[16] = 1'b0;
        if (t == 4) qcmp[16] = 1'b0;
        chk($sformatf("R6 overlap t%0d trig", t), 32'(trig),
            (t >= 3 && t <= 4) ? 32'h10000 : 32'h0);
        chk($sformatf("R7 overlap t%0d event", t), 32'(evt), 32'h0);
        chk($sformatf("R8 overlap t%0d hold", t), 32'(hold), 32'(t >= 3 && t <= 4));
      end
    end

    ext_case(4, 1'b0);
    ext_case(3, 1'b1);
    ext_case(1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule